// File: doc/BRIEF.md
# Cascaded Sigma-Delta Error-Cancellation Combiner

This block sits behind a three-stage cascaded sigma-delta modulator and merges the three stage outputs into one signed word per modulator sample, so that the quantization error of the earlier stages cancels. Each accepted sample produces this result: the first-stage value delayed by two samples, minus the second-order difference (1 − z⁻¹)² of the second-stage value, plus the fourth-order difference (1 − z⁻¹)⁴ of the third-stage value. Stages one and two are one-bit streams. Stage three is either a one-bit stream or a multibit code from a pipelined quantizer whose trailing stages can be switched off.

A standard-select input picks one of six configurations, ordered from the narrowest channel to the widest. It sets the loop order, the final-quantizer resolution and the oversampling ratio. The ratio is exported for a downstream decimator. All cancellation is digital, and the block drives nothing back towards the analog loop.

Top module: `sd_cancel_combiner`

## Requirements
- R1: After synchronous reset with `std_sel` = 0, `out_valid` is 0, `out_data` is 0 and `osr_ratio` is 128.
- R2: In second-order mode (`std_sel` = 0), each valid result equals y1[n-2] − (y2[n] − 2·y2[n-1] + y2[n-2]). The third-stage input has no effect.
- R3: In fourth-order one-bit modes (`std_sel` 1 to 3), each valid result also adds y3[n] − 4·y3[n-1] + 6·y3[n-2] − 4·y3[n-3] + y3[n-4]. Here y3 is taken from bit 5 (the MSB) of `s3_code`.
- R4: In multibit modes (`std_sel` 4 and 5), y3 is `s3_code` read as a 6-bit two's-complement value (default parameter), and the same fourth-order sum applies.
- R5: A one-bit input of 1 maps to +1 and a 0 maps to −1. This holds for `s1_bit`, for `s2_bit`, and for `s3_code[5]` in one-bit modes.
- R6: A result appears on `out_data` with `out_valid` high exactly one clock after the edge that accepted `in_valid`. Cycles without `in_valid` leave the history untouched, hold `out_data`, and keep `out_valid` low.
- R7: After reset or any change of the effective `std_sel`, all history is cleared, and the first four accepted samples give no `out_valid`. The fifth sample gives a valid result.
- R8: `osr_ratio` is registered one clock after `std_sel` and follows 0→128, 1→32, 2→20, 3→16, 4→12, 5→8.
- R9: `std_sel` values 6 and 7 behave exactly like 5.
- R10: In multibit modes, `s3_width` = w (1 to 5) keeps only the top w bits of `s3_code` and forces the lower bits to 0. A value of 0, 6 or 7 uses all 6 bits.
- R11: Full-scale inputs give exact results with no overflow. For example, third-stage codes alternating between 31 and −32 give a fourth-order term of ±504.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A new set of stage outputs is present |
| s1_bit | input | 1 | First-stage one-bit output |
| s2_bit | input | 1 | Second-stage one-bit output |
| s3_code | input | 6 | Third-stage code (MSB used in one-bit modes) |
| s3_width | input | 3 | Active third-stage bits in multibit modes |
| std_sel | input | 3 | Standard/configuration select |
| out_valid | output | 1 | Result strobe |
| out_data | output | 12 | Signed combined result |
| osr_ratio | output | 8 | Oversampling ratio for the decimator |

## Verification
A corrupted register in either difference chain or in the delay line shows as a wrong `out_data` on the very next valid result. It keeps showing for up to four further samples, until the bad value leaves the chain. A fill counter that is wrong appears at once as `out_valid` rising too early or too late after a configuration change. A stale history that is not cleared is exposed by comparing the fifth post-change result against a model that starts from zero history. Each mode is driven with random streams and full-scale patterns, and each result is compared against a bench model of the difference equation.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic [1:0] {
    CFG_O2_1B = 2'd0,
    CFG_O4_1B = 2'd1,
    CFG_O4_MB = 2'd2
  } cfg_e;

  localparam int NUM_STD = 6;

  function automatic logic [2:0] clip_std(input logic [2:0] s);
    return (s > 3'(NUM_STD - 1)) ? 3'(NUM_STD - 1) : s;
  endfunction

  function automatic cfg_e std_to_cfg(input logic [2:0] s);
    case (s)
      3'd0:        return CFG_O2_1B;
      3'd1, 3'd2,
      3'd3:        return CFG_O4_1B;
      default:     return CFG_O4_MB;
    endcase
  endfunction

  function automatic logic [7:0] std_to_osr(input logic [2:0] s);
    case (s)
      3'd0:    return 8'd128;
      3'd1:    return 8'd32;
      3'd2:    return 8'd20;
      3'd3:    return 8'd16;
      3'd4:    return 8'd12;
      default: return 8'd8;
    endcase
  endfunction

endpackage

// File: rtl/sdc_term_map.sv
module sdc_term_map
  import sdc_pkg::*;
#(
  parameter int S3W       = 6,
  parameter bit S3_OFFSET = 1'b0,
  parameter int WSEL_W    = $clog2(S3W + 1)
) (
  input  logic                  s1_bit,
  input  logic                  s2_bit,
  input  logic [S3W-1:0]        s3_code,
  input  logic [WSEL_W-1:0]     s3_width,
  input  cfg_e                  cfg,
  output logic signed [1:0]     y1,
  output logic signed [1:0]     y2,
  output logic signed [S3W-1:0] y3
);

  logic [S3W-1:0] keep_mask;
  logic [S3W-1:0] masked;
  int unsigned    act_w;

  always_comb begin
    act_w = (s3_width == '0 || int'(s3_width) > S3W) ? S3W : int'(s3_width);
    keep_mask = '1;
    keep_mask = keep_mask << (S3W - act_w);
    masked = s3_code & keep_mask;
  end

  assign y1 = s1_bit ? 2'sd1 : -2'sd1;
  assign y2 = s2_bit ? 2'sd1 : -2'sd1;

  always_comb begin
    case (cfg)
      CFG_O2_1B: y3 = '0;
      CFG_O4_1B: y3 = s3_code[S3W-1] ? S3W'(1) : -S3W'(1);
      default: begin
        if (S3_OFFSET) y3 = {~masked[S3W-1], masked[S3W-2:0]};
        else           y3 = masked;
      end
    endcase
  end

endmodule

// File: rtl/sdc_diff_chain.sv
module sdc_diff_chain #(
  parameter int IN_W  = 6,
  parameter int ORDER = 4,
  parameter int OW    = IN_W + ORDER
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 adv,
  input  logic signed [IN_W-1:0] x,
  output logic signed [OW-1:0] y
);

  logic signed [OW-1:0] stg [ORDER+1];

  assign stg[0] = OW'(x);

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    logic signed [OW-1:0] prev_q;
    always_ff @(posedge clk) begin
      if (rst || clr)   prev_q <= '0;
      else if (adv)     prev_q <= stg[k];
    end
    assign stg[k+1] = stg[k] - prev_q;
  end

  assign y = stg[ORDER];

endmodule

// File: rtl/sdc_delay_line.sv
module sdc_delay_line #(
  parameter int W     = 2,
  parameter int DEPTH = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                adv,
  input  logic signed [W-1:0] x,
  output logic signed [W-1:0] y
);

  logic signed [W-1:0] tap [DEPTH+1];

  assign tap[0] = x;

  for (genvar k = 0; k < DEPTH; k++) begin : g_tap
    logic signed [W-1:0] t_q;
    always_ff @(posedge clk) begin
      if (rst || clr) t_q <= '0;
      else if (adv)   t_q <= tap[k];
    end
    assign tap[k+1] = t_q;
  end

  assign y = tap[DEPTH];

endmodule

// File: rtl/sd_cancel_combiner.sv
module sd_cancel_combiner
  import sdc_pkg::*;
#(
  parameter int S3W       = 6,
  parameter int OUT_W     = S3W + 6,
  parameter bit S3_OFFSET = 1'b0,
  parameter int WARMUP    = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic                       s1_bit,
  input  logic                       s2_bit,
  input  logic [S3W-1:0]             s3_code,
  input  logic [$clog2(S3W+1)-1:0]   s3_width,
  input  logic [2:0]                 std_sel,
  output logic                       out_valid,
  output logic signed [OUT_W-1:0]    out_data,
  output logic [7:0]                 osr_ratio
);

  localparam int WSEL_W = $clog2(S3W + 1);
  localparam int D2_W   = 2 + 2;
  localparam int D4_W   = S3W + 4;
  localparam int FILL_W = $clog2(WARMUP + 1);
  localparam int BOUND  = 5 + (16 << (S3W - 1));

  logic [2:0] std_eff, std_q;
  cfg_e       cfg;
  logic       change, adv;

  assign std_eff = clip_std(std_sel);
  assign cfg     = std_to_cfg(std_eff);
  assign change  = (std_eff != std_q);
  assign adv     = in_valid && !change;

  always_ff @(posedge clk) begin
    std_q     <= std_eff;
    osr_ratio <= std_to_osr(std_eff);
  end

  logic signed [1:0]     y1, y2;
  logic signed [S3W-1:0] y3;

  sdc_term_map #(.S3W(S3W), .S3_OFFSET(S3_OFFSET), .WSEL_W(WSEL_W)) u_map (
    .s1_bit(s1_bit), .s2_bit(s2_bit), .s3_code(s3_code),
    .s3_width(s3_width), .cfg(cfg), .y1(y1), .y2(y2), .y3(y3)
  );

  logic signed [1:0]      d1;
  logic signed [D2_W-1:0] dd2;
  logic signed [D4_W-1:0] dd4;

  sdc_delay_line #(.W(2), .DEPTH(2)) u_dly1 (
    .clk(clk), .rst(rst), .clr(change), .adv(adv), .x(y1), .y(d1)
  );

  sdc_diff_chain #(.IN_W(2), .ORDER(2), .OW(D2_W)) u_dif2 (
    .clk(clk), .rst(rst), .clr(change), .adv(adv), .x(y2), .y(dd2)
  );

  sdc_diff_chain #(.IN_W(S3W), .ORDER(4), .OW(D4_W)) u_dif4 (
    .clk(clk), .rst(rst), .clr(change), .adv(adv), .x(y3), .y(dd4)
  );

  logic signed [OUT_W-1:0] sum;
  assign sum = OUT_W'(d1) - OUT_W'(dd2) + OUT_W'(dd4);

  logic [FILL_W-1:0] fill;
  logic              ready;
  assign ready = (fill == FILL_W'(WARMUP));

  always_ff @(posedge clk) begin
    if (rst || change) begin
      fill <= '0;
    end else if (adv && !ready) begin
      fill <= fill + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= adv && ready;
      if (adv && ready) out_data <= sum;
    end
  end

  // R6
  lat_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R7
  warm_chk: assert property (@(posedge clk) disable iff (rst)
    change |=> !out_valid);

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data <= OUT_W'(BOUND) && out_data >= -OUT_W'(BOUND)));

  // R2
  order2_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(cfg == CFG_O2_1B)) |-> (out_data <= 5 && out_data >= -5));

  // R8
  osr_set_chk: assert property (@(posedge clk) disable iff (rst)
    osr_ratio == 8'd128 || osr_ratio == 8'd32 || osr_ratio == 8'd20 ||
    osr_ratio == 8'd16  || osr_ratio == 8'd12 || osr_ratio == 8'd8);

endmodule

// File: tb/sd_cancel_combiner_test.sv
module sd_cancel_combiner_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic s1_bit = 1'b0, s2_bit = 1'b0;
  logic [5:0] s3_code = '0;
  logic [2:0] s3_width = '0;
  logic [2:0] std_sel = '0;
  logic out_valid;
  logic signed [11:0] out_data;
  logic [7:0] osr_ratio;

  sd_cancel_combiner uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .s1_bit(s1_bit),
    .s2_bit(s2_bit), .s3_code(s3_code), .s3_width(s3_width),
    .std_sel(std_sel), .out_valid(out_valid), .out_data(out_data),
    .osr_ratio(osr_ratio)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int h1[5], h2[5], h3[5];
  int fill_m = 0;
  int last_out = 0;
  int seed = 32'h5eed1;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff_std(input int s);
    return (s > 5) ? 5 : s;
  endfunction

  function automatic int osr_of(input int s);
    case (eff_std(s))
      0: return 128; 1: return 32; 2: return 20;
      3: return 16;  4: return 12; default: return 8;
    endcase
  endfunction

  function automatic int map3(input int s, input logic [5:0] c, input int w);
    int ww; logic [5:0] m;
    s = eff_std(s);
    if (s == 0) return 0;
    if (s <= 3) return c[5] ? 1 : -1;
    ww = (w == 0 || w > 6) ? 6 : w;
    m = c & (6'h3f << (6 - ww));
    return int'($signed(m));
  endfunction

  task automatic clear_model();
    for (int i = 0; i < 5; i++) begin h1[i] = 0; h2[i] = 0; h3[i] = 0; end
    fill_m = 0;
  endtask

  task automatic send(input logic b1, input logic b2, input logic [5:0] c,
                      input int w, input string tag);
    int e;
    @(negedge clk);
    in_valid = 1'b1; s1_bit = b1; s2_bit = b2; s3_code = c; s3_width = 3'(w);
    for (int i = 4; i > 0; i--) begin h1[i] = h1[i-1]; h2[i] = h2[i-1]; h3[i] = h3[i-1]; end
    h1[0] = b1 ? 1 : -1;
    h2[0] = b2 ? 1 : -1;
    h3[0] = map3(int'(std_sel), c, w);
    e = h1[2] - (h2[0] - 2*h2[1] + h2[2])
        + (h3[0] - 4*h3[1] + 6*h3[2] - 4*h3[3] + h3[4]);
    @(posedge clk); #1;
    in_valid = 1'b0;
    if (fill_m < 4) begin
      fill_m++;
      chk(out_valid == 1'b0, {"R7 warmup ", tag}, int'(out_valid), 0);
    end else begin
      chk(out_valid == 1'b1, {"R6 valid ", tag}, int'(out_valid), 1);
      chk(int'(out_data) == e, tag, int'(out_data), e);
      last_out = e;
    end
  endtask

  task automatic set_cfg(input int s);
    bit chg;
    chg = (eff_std(s) != eff_std(int'(std_sel)));
    @(negedge clk);
    std_sel = 3'(s); in_valid = 1'b0;
    @(posedge clk); #1;
    chk(int'(osr_ratio) == osr_of(s), "R8 osr", int'(osr_ratio), osr_of(s));
    chk(out_valid == 1'b0, "R7 no valid on change", int'(out_valid), 0);
    if (chg) clear_model();
  endtask

  task automatic rand_run(input int n, input int w_fixed, input string tag);
    int w;
    for (int i = 0; i < n; i++) begin
      w = (w_fixed < 0) ? int'($urandom() % 8) : w_fixed;
      send(1'($urandom()), 1'($urandom()), 6'($urandom()), w, tag);
    end
  endtask

  initial begin
    #1500000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(seed));
    clear_model();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1
    chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
    chk(out_data == 0, "R1 data", int'(out_data), 0);
    chk(osr_ratio == 8'd128, "R1 osr", int'(osr_ratio), 128);

    // R2 and R5: second-order mode, third stage ignored
    rand_run(30, 6, "R2 order2");
    send(1, 1, 6'h00, 6, "R5 ones");
    send(0, 0, 6'h3f, 6, "R5 zeros");
    send(1, 0, 6'h20, 6, "R2 s3 ignored");

    // R3 fourth-order one-bit modes
    for (int s = 1; s <= 3; s++) begin
      set_cfg(s);
      rand_run(40, 6, "R3 order4 1b");
    end
    set_cfg(2);
    for (int i = 0; i < 10; i++) send(i[0], ~i[0], {i[0], 5'h0}, 6, "R3 alternating");

    // R4 multibit, full width; R11 extremes
    set_cfg(4);
    rand_run(40, 6, "R4 multibit");
    for (int i = 0; i < 10; i++)
      send(1, 0, i[0] ? 6'h1f : 6'h20, 6, "R11 full scale");
    chk(last_out == 504 || last_out == -504 || last_out > 500 || last_out < -500,
        "R11 magnitude", last_out, 504);

    // R10 reduced active bits
    set_cfg(5);
    rand_run(40, -1, "R10 width");
    for (int i = 0; i < 6; i++) send(0, 1, 6'b011111, 1, "R10 width1");

    // R9 select above range aliases widest
    @(negedge clk); std_sel = 3'd7;
    @(posedge clk); #1;
    chk(osr_ratio == 8'd8, "R9 osr", int'(osr_ratio), 8);
    rand_run(12, 0, "R9 alias");
    set_cfg(6);
    rand_run(6, 6, "R9 alias 6");

    // R6 idle cycles hold data and history
    repeat (5) begin
      @(posedge clk); #1;
      chk(out_valid == 1'b0, "R6 idle valid", int'(out_valid), 0);
      chk(int'(out_data) == last_out, "R6 idle hold", int'(out_data), last_out);
    end
    rand_run(6, 6, "R6 after idle");

    // R7 mid-stream change then reset
    set_cfg(0);
    rand_run(8, 6, "R7 after change");
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
    clear_model();
    #1;
    chk(out_valid == 1'b0, "R1 reset again", int'(out_valid), 0);
    rand_run(10, 6, "R7 after reset");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule